// File: doc/BRIEF.md
# Scanline and Frame Timing Controller

This block produces the line and frame timing for a 240x160 handheld LCD. A single down-counter times each phase of a scanline. A four-state machine moves through draw, horizontal blank, blanked draw and blanked horizontal blank. The line counter steps at the end of every horizontal blank and wraps after the last blanked line. Level flags report horizontal blank, vertical blank and line-compare match. Single-cycle pulses tell the interrupt controller and the DMA engine when these events occur, and a render strobe marks the start of each visible line that the pixel pipeline must produce.

The block also keeps the running reference points of the two rotate/scale backgrounds. Each visible line advances them by the programmed per-line deltas. They are reloaded from the programmed origins when vertical blank begins, or at once when software writes an origin. All timing advances only on cycles where the system-cycle enable is high, so the block can run from a faster clock.

Top module: `lcd_line_timer`

## Requirements
- R1: While reset is held, and on release, the phase is draw (code 0), the line is 0, all flags, pulses and the render strobe are low, and every internal reference point is 0.
- R2: The draw phase lasts DRAW_CYC enabled cycles and horizontal blank lasts HBL_CYC enabled cycles. Cycles with cyc_en low advance nothing and produce no pulse. Phase codes are 0 draw, 1 horizontal blank, 2 blanked draw and 3 blanked horizontal blank.
- R3: The line counter increments when horizontal blank ends. It counts VIS_LINES visible and VBL_LINES blanked lines. After the last line it returns to 0, with both blank flags cleared and the phase set to draw.
- R4: flag_hbl rises when any draw phase ends, blanked lines included, and falls when the line changes. irq_hbl pulses at that rise when irq_en_hbl is high.
- R5: dma_hbl pulses when a draw phase ends on a visible line only.
- R6: When the line reaches VIS_LINES, flag_vbl sets. dma_vbl and frame_done pulse once. irq_vbl pulses if irq_en_vbl is high.
- R7: flag_cmp is recomputed as (new line == cmp_line) only when the line changes. irq_cmp pulses on such a change when the match holds and irq_en_cmp is high.
- R8: render_stb pulses when a visible line's draw phase begins, including line 0 after the wrap, but not after reset.
- R9: When a visible line other than the last ends, each background's internal X gains its sign-extended 16-bit X delta and internal Y gains its sign-extended 16-bit Y delta. A change to a programmed origin without a write strobe does not alter the internal point.
- R10: On entry to vertical blank every internal point is reloaded from its programmed origin.
- R11: A write strobe for an origin loads the internal point on the next clock edge. The write wins over a per-line step in the same cycle.
- R12: Every IRQ, DMA, frame-done and render output is high for exactly one clock per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_en | input | 1 | One-per-system-cycle enable |
| cmp_line | input | LINE_W | Line number for the compare flag |
| irq_en_hbl | input | 1 | Horizontal-blank interrupt enable |
| irq_en_vbl | input | 1 | Vertical-blank interrupt enable |
| irq_en_cmp | input | 1 | Line-compare interrupt enable |
| org_x | input | NUM_AFF*REF_W | Programmed X origins, background g at slice g |
| org_y | input | NUM_AFF*REF_W | Programmed Y origins |
| org_x_wr | input | NUM_AFF | X origin write strobes |
| org_y_wr | input | NUM_AFF | Y origin write strobes |
| dlt_x | input | NUM_AFF*DELTA_W | Signed per-line X deltas |
| dlt_y | input | NUM_AFF*DELTA_W | Signed per-line Y deltas |
| phase | output | 2 | Current phase code |
| line | output | LINE_W | Current line |
| flag_hbl | output | 1 | Horizontal-blank flag |
| flag_vbl | output | 1 | Vertical-blank flag |
| flag_cmp | output | 1 | Line-compare flag |
| irq_hbl | output | 1 | Horizontal-blank interrupt pulse |
| irq_vbl | output | 1 | Vertical-blank interrupt pulse |
| irq_cmp | output | 1 | Line-compare interrupt pulse |
| dma_hbl | output | 1 | Horizontal-blank DMA strobe |
| dma_vbl | output | 1 | Vertical-blank DMA strobe |
| frame_done | output | 1 | End-of-visible-frame strobe |
| render_stb | output | 1 | Start of a visible line draw |
| cur_x | output | NUM_AFF*REF_W | Internal X reference points |
| cur_y | output | NUM_AFF*REF_W | Internal Y reference points |

## Verification
A software write to a reference origin can land on the same clock edge as the per-line step of that point. The step and vertical-blank reload sequencing can also coincide with it. The bench raises a write strobe in the cycle just before the edge that ends a visible line's horizontal blank. It then expects the written origin rather than the stepped value, while the other coordinate, which was not written, still steps. It also sets the compare line to the current line in mid-line and confirms the flag waits for the next line change.

// File: rtl/lcd_timing_pkg.sv
package lcd_timing_pkg;

  typedef enum logic [1:0] {
    PH_DRAW  = 2'd0,
    PH_HBL   = 2'd1,
    PH_VDRAW = 2'd2,
    PH_VHBL  = 2'd3
  } lcd_phase_e;

  // One-cycle event indications from the phase sequencer.
  typedef struct packed {
    logic hbl_start;   // any draw phase ended
    logic vis_hbl;     // a visible draw phase ended
    logic line_chg;    // line counter changes this cycle
    logic vis_step;    // moving from one visible line to the next
    logic vbl_entry;   // line reaches the first blanked line
    logic wrap;        // line returns to 0
  } lcd_evt_t;

endpackage

// File: rtl/lcd_phase_seq.sv
module lcd_phase_seq
  import lcd_timing_pkg::*;
#(
  parameter int DRAW_CYC  = 1006,
  parameter int HBL_CYC   = 226,
  parameter int VIS_LINES = 160,
  parameter int VBL_LINES = 68,
  parameter int LINE_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_en,
  output lcd_phase_e        phase_q,
  output logic [LINE_W-1:0] line_q,
  output logic [LINE_W-1:0] line_d,
  output lcd_evt_t          evt
);
  localparam int MAX_PH    = (DRAW_CYC > HBL_CYC) ? DRAW_CYC : HBL_CYC;
  localparam int CNT_W     = $clog2(MAX_PH + 1);
  localparam int LAST_LINE = VIS_LINES + VBL_LINES - 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  lcd_phase_e       phase_d;
  logic             done;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    line_d  = line_q;
    evt     = '0;
    done    = cyc_en && (cnt_q == '0);
    if (cyc_en && (cnt_q != '0)) cnt_d = cnt_q - 1'b1;
    if (done) begin
      unique case (phase_q)
        PH_DRAW: begin
          phase_d       = PH_HBL;
          cnt_d         = CNT_W'(HBL_CYC - 1);
          evt.hbl_start = 1'b1;
          evt.vis_hbl   = 1'b1;
        end
        PH_HBL: begin
          cnt_d        = CNT_W'(DRAW_CYC - 1);
          line_d       = line_q + 1'b1;
          evt.line_chg = 1'b1;
          if (line_q == LINE_W'(VIS_LINES - 1)) begin
            phase_d       = PH_VDRAW;
            evt.vbl_entry = 1'b1;
          end else begin
            phase_d      = PH_DRAW;
            evt.vis_step = 1'b1;
          end
        end
        PH_VDRAW: begin
          phase_d       = PH_VHBL;
          cnt_d         = CNT_W'(HBL_CYC - 1);
          evt.hbl_start = 1'b1;
        end
        default: begin
          cnt_d        = CNT_W'(DRAW_CYC - 1);
          evt.line_chg = 1'b1;
          if (line_q == LINE_W'(LAST_LINE)) begin
            line_d   = '0;
            phase_d  = PH_DRAW;
            evt.wrap = 1'b1;
          end else begin
            line_d  = line_q + 1'b1;
            phase_d = PH_VDRAW;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_DRAW;
      cnt_q   <= CNT_W'(DRAW_CYC - 1);
      line_q  <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      line_q  <= line_d;
    end
  end

endmodule

// File: rtl/lcd_status_gen.sv
module lcd_status_gen
  import lcd_timing_pkg::*;
#(
  parameter int LINE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  lcd_evt_t          evt,
  input  logic [LINE_W-1:0] line_d,
  input  logic [LINE_W-1:0] cmp_line,
  input  logic              irq_en_hbl,
  input  logic              irq_en_vbl,
  input  logic              irq_en_cmp,
  output logic              flag_hbl,
  output logic              flag_vbl,
  output logic              flag_cmp,
  output logic              irq_hbl,
  output logic              irq_vbl,
  output logic              irq_cmp,
  output logic              dma_hbl,
  output logic              dma_vbl,
  output logic              frame_done,
  output logic              render_stb
);
  logic hbl_d, vbl_d, cmp_d, match;

  always_comb begin
    match = (line_d == cmp_line);
    hbl_d = flag_hbl;
    vbl_d = flag_vbl;
    cmp_d = flag_cmp;
    if (evt.hbl_start) hbl_d = 1'b1;
    if (evt.line_chg) begin
      hbl_d = 1'b0;
      cmp_d = match;
    end
    if (evt.vbl_entry) vbl_d = 1'b1;
    if (evt.wrap)      vbl_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_hbl   <= 1'b0;
      flag_vbl   <= 1'b0;
      flag_cmp   <= 1'b0;
      irq_hbl    <= 1'b0;
      irq_vbl    <= 1'b0;
      irq_cmp    <= 1'b0;
      dma_hbl    <= 1'b0;
      dma_vbl    <= 1'b0;
      frame_done <= 1'b0;
      render_stb <= 1'b0;
    end else begin
      flag_hbl   <= hbl_d;
      flag_vbl   <= vbl_d;
      flag_cmp   <= cmp_d;
      irq_hbl    <= evt.hbl_start && irq_en_hbl;
      irq_vbl    <= evt.vbl_entry && irq_en_vbl;
      irq_cmp    <= evt.line_chg && match && irq_en_cmp;
      dma_hbl    <= evt.vis_hbl;
      dma_vbl    <= evt.vbl_entry;
      frame_done <= evt.vbl_entry;
      render_stb <= evt.vis_step || evt.wrap;
    end
  end

endmodule

// File: rtl/lcd_affine_ref.sv
module lcd_affine_ref #(
  parameter int REF_W   = 32,
  parameter int DELTA_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_x,
  input  logic               wr_y,
  input  logic [REF_W-1:0]   org_x,
  input  logic [REF_W-1:0]   org_y,
  input  logic [DELTA_W-1:0] dlt_x,
  input  logic [DELTA_W-1:0] dlt_y,
  input  logic               step,
  input  logic               reload,
  output logic [REF_W-1:0]   cur_x,
  output logic [REF_W-1:0]   cur_y
);
  localparam int EXT_W = REF_W - DELTA_W;

  logic [REF_W-1:0] x_d, y_d, sx, sy;

  always_comb begin
    sx  = {{EXT_W{dlt_x[DELTA_W-1]}}, dlt_x};
    sy  = {{EXT_W{dlt_y[DELTA_W-1]}}, dlt_y};
    x_d = cur_x;
    y_d = cur_y;
    if (step) begin
      x_d = cur_x + sx;
      y_d = cur_y + sy;
    end
    if (reload || wr_x) x_d = org_x;
    if (reload || wr_y) y_d = org_y;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_x <= '0;
      cur_y <= '0;
    end else begin
      cur_x <= x_d;
      cur_y <= y_d;
    end
  end

endmodule

// File: rtl/lcd_line_timer.sv
module lcd_line_timer
  import lcd_timing_pkg::*;
#(
  parameter int DRAW_CYC  = 1006,
  parameter int HBL_CYC   = 226,
  parameter int VIS_LINES = 160,
  parameter int VBL_LINES = 68,
  parameter int LINE_W    = 8,
  parameter int NUM_AFF   = 2,
  parameter int REF_W     = 32,
  parameter int DELTA_W   = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cyc_en,
  input  logic [LINE_W-1:0]          cmp_line,
  input  logic                       irq_en_hbl,
  input  logic                       irq_en_vbl,
  input  logic                       irq_en_cmp,
  input  logic [NUM_AFF*REF_W-1:0]   org_x,
  input  logic [NUM_AFF*REF_W-1:0]   org_y,
  input  logic [NUM_AFF-1:0]         org_x_wr,
  input  logic [NUM_AFF-1:0]         org_y_wr,
  input  logic [NUM_AFF*DELTA_W-1:0] dlt_x,
  input  logic [NUM_AFF*DELTA_W-1:0] dlt_y,
  output logic [1:0]                 phase,
  output logic [LINE_W-1:0]          line,
  output logic                       flag_hbl,
  output logic                       flag_vbl,
  output logic                       flag_cmp,
  output logic                       irq_hbl,
  output logic                       irq_vbl,
  output logic                       irq_cmp,
  output logic                       dma_hbl,
  output logic                       dma_vbl,
  output logic                       frame_done,
  output logic                       render_stb,
  output logic [NUM_AFF*REF_W-1:0]   cur_x,
  output logic [NUM_AFF*REF_W-1:0]   cur_y
);
  lcd_phase_e        phase_q;
  logic [LINE_W-1:0] line_d;
  lcd_evt_t          evt;

  lcd_phase_seq #(
    .DRAW_CYC (DRAW_CYC),
    .HBL_CYC  (HBL_CYC),
    .VIS_LINES(VIS_LINES),
    .VBL_LINES(VBL_LINES),
    .LINE_W   (LINE_W)
  ) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .cyc_en (cyc_en),
    .phase_q(phase_q),
    .line_q (line),
    .line_d (line_d),
    .evt    (evt)
  );

  assign phase = phase_q;

  lcd_status_gen #(.LINE_W(LINE_W)) u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt       (evt),
    .line_d    (line_d),
    .cmp_line  (cmp_line),
    .irq_en_hbl(irq_en_hbl),
    .irq_en_vbl(irq_en_vbl),
    .irq_en_cmp(irq_en_cmp),
    .flag_hbl  (flag_hbl),
    .flag_vbl  (flag_vbl),
    .flag_cmp  (flag_cmp),
    .irq_hbl   (irq_hbl),
    .irq_vbl   (irq_vbl),
    .irq_cmp   (irq_cmp),
    .dma_hbl   (dma_hbl),
    .dma_vbl   (dma_vbl),
    .frame_done(frame_done),
    .render_stb(render_stb)
  );

  for (genvar g = 0; g < NUM_AFF; g++) begin : g_aff
    lcd_affine_ref #(.REF_W(REF_W), .DELTA_W(DELTA_W)) u_aff (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_x  (org_x_wr[g]),
      .wr_y  (org_y_wr[g]),
      .org_x (org_x[g*REF_W +: REF_W]),
      .org_y (org_y[g*REF_W +: REF_W]),
      .dlt_x (dlt_x[g*DELTA_W +: DELTA_W]),
      .dlt_y (dlt_y[g*DELTA_W +: DELTA_W]),
      .step  (evt.vis_step),
      .reload(evt.vbl_entry),
      .cur_x (cur_x[g*REF_W +: REF_W]),
      .cur_y (cur_y[g*REF_W +: REF_W])
    );
  end

endmodule

// File: rtl/lcd_line_timer_chk.sv
module lcd_line_timer_chk #(
  parameter int VIS_LINES = 160,
  parameter int VBL_LINES = 68,
  parameter int LINE_W    = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        phase,
  input logic [LINE_W-1:0] line,
  input logic              flag_hbl,
  input logic              flag_vbl,
  input logic              flag_cmp,
  input logic              irq_hbl,
  input logic              irq_cmp,
  input logic              dma_hbl,
  input logic              dma_vbl,
  input logic              frame_done,
  input logic              render_stb
);
  localparam logic [LINE_W-1:0] LAST = LINE_W'(VIS_LINES + VBL_LINES - 1);
  localparam logic [LINE_W-1:0] VIS  = LINE_W'(VIS_LINES);

  assert_line_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    line <= LAST);

  assert_wrap_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (line == '0 && $past(line) == LAST) |-> (!flag_hbl && !flag_vbl && phase == 2'd0));

  assert_hbl_matches_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flag_hbl == (phase == 2'd1 || phase == 2'd3));

  assert_dma_hbl_visible_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dma_hbl |-> (flag_hbl && !flag_vbl && line < VIS));

  assert_vbl_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dma_vbl |-> (flag_vbl && line == VIS && frame_done));

  assert_cmp_on_line_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(flag_cmp) |-> !$stable(line));

  assert_irq_cmp_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_cmp |-> flag_cmp);

  assert_render_draw_R8: assert property (@(posedge clk) disable iff (!rst_n)
    render_stb |-> (phase == 2'd0 && line < VIS));

  assert_irq_hbl_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hbl |=> !irq_hbl);

  assert_dma_vbl_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    dma_vbl |=> !dma_vbl);

endmodule

bind lcd_line_timer lcd_line_timer_chk #(
  .VIS_LINES(VIS_LINES),
  .VBL_LINES(VBL_LINES),
  .LINE_W   (LINE_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .phase     (phase),
  .line      (line),
  .flag_hbl  (flag_hbl),
  .flag_vbl  (flag_vbl),
  .flag_cmp  (flag_cmp),
  .irq_hbl   (irq_hbl),
  .irq_cmp   (irq_cmp),
  .dma_hbl   (dma_hbl),
  .dma_vbl   (dma_vbl),
  .frame_done(frame_done),
  .render_stb(render_stb)
);

// File: tb/test_lcd_line_timer.sv
module test_lcd_line_timer;
  localparam int DRAW = 6, HBL = 3, VIS = 4, VBL = 3;
  localparam int LW = 8, NA = 2, RW = 32, DW = 16;
  localparam int FRAME = (DRAW + HBL) * (VIS + VBL);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, cyc_en, en_h, en_v, en_c;
  logic [LW-1:0] cmp_line;
  logic [NA*RW-1:0] org_x, org_y, cur_x, cur_y;
  logic [NA-1:0] wx, wy;
  logic [NA*DW-1:0] dx, dy;
  logic [1:0] phase;
  logic [LW-1:0] line;
  logic f_h, f_v, f_c, i_h, i_v, i_c, d_h, d_v, fdone, rstb;

  lcd_line_timer #(.DRAW_CYC(DRAW), .HBL_CYC(HBL), .VIS_LINES(VIS), .VBL_LINES(VBL),
    .LINE_W(LW), .NUM_AFF(NA), .REF_W(RW), .DELTA_W(DW)) i_lcd_line_timer (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .cmp_line(cmp_line),
    .irq_en_hbl(en_h), .irq_en_vbl(en_v), .irq_en_cmp(en_c),
    .org_x(org_x), .org_y(org_y), .org_x_wr(wx), .org_y_wr(wy), .dlt_x(dx), .dlt_y(dy),
    .phase(phase), .line(line), .flag_hbl(f_h), .flag_vbl(f_v), .flag_cmp(f_c),
    .irq_hbl(i_h), .irq_vbl(i_v), .irq_cmp(i_c), .dma_hbl(d_h), .dma_vbl(d_v),
    .frame_done(fdone), .render_stb(rstb), .cur_x(cur_x), .cur_y(cur_y));

  int n_chk = 0, n_bad = 0, nedge = 0, cyc = 0;

  typedef struct packed {
    logic [7:0] adv;
    logic [1:0] ph;
    logic [3:0] ln;
    logic       hb;
    logic       vb;
  } vec_t;

  // Advance counts with the phase, line and flags expected afterwards.
  localparam vec_t VEC [10] = '{
    '{8'd0,  2'd0, 4'd0, 1'b0, 1'b0},
    '{8'd5,  2'd0, 4'd0, 1'b0, 1'b0},
    '{8'd1,  2'd1, 4'd0, 1'b1, 1'b0},
    '{8'd2,  2'd1, 4'd0, 1'b1, 1'b0},
    '{8'd1,  2'd0, 4'd1, 1'b0, 1'b0},
    '{8'd27, 2'd2, 4'd4, 1'b0, 1'b1},
    '{8'd6,  2'd3, 4'd4, 1'b1, 1'b1},
    '{8'd21, 2'd0, 4'd0, 1'b0, 1'b0},
    '{8'd62, 2'd3, 4'd6, 1'b1, 1'b1},
    '{8'd1,  2'd0, 4'd0, 1'b0, 1'b0}
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    if (cyc_en) nedge++;
    @(negedge clk);
  endtask

  task automatic adv_to(input int target);
    while (nedge < target) step();
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below 20000", cyc);
      finish_run();
    end
  end

  int c_ih, c_dh, c_iv, c_dv, c_fd, c_rs, c_ic, c_bad;

  task automatic run_frame();
    c_ih = 0; c_dh = 0; c_iv = 0; c_dv = 0; c_fd = 0; c_rs = 0; c_ic = 0; c_bad = 0;
    for (int k = 0; k < FRAME; k++) begin
      step();
      c_ih += int'(i_h); c_dh += int'(d_h); c_iv += int'(i_v);
      c_dv += int'(d_v); c_fd += int'(fdone); c_rs += int'(rstb); c_ic += int'(i_c);
      if (d_h && f_v) c_bad++;
      if (d_v && line != LW'(VIS)) c_bad++;
    end
  endtask

  initial begin
    rst_n = 1'b0; cyc_en = 1'b0; en_h = 1'b0; en_v = 1'b0; en_c = 1'b0;
    cmp_line = 8'hFF; org_x = '0; org_y = '0; wx = '0; wy = '0; dx = '0; dy = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 phase in reset", 32'(phase), 0);
    chk("R1 pulses in reset", {i_h, i_v, i_c, d_h, d_v, fdone, rstb}, 0);
    rst_n = 1'b1;
    step();
    chk("R1 line after release", 32'(line), 0);
    chk("R1 flags after release", {f_h, f_v, f_c}, 0);
    chk("R1 ref points", 32'(cur_x | cur_y), 0);

    // Vector walk: R2 phase lengths, R3 line count and wrap, R4/R6 flags
    cyc_en = 1'b1;
    foreach (VEC[i]) begin
      repeat (int'(VEC[i].adv)) step();
      chk($sformatf("R2 phase vec%0d", i), 32'(phase), 32'(VEC[i].ph));
      chk($sformatf("R3 line vec%0d", i), 32'(line), 32'(VEC[i].ln));
      chk($sformatf("R4 hbl flag vec%0d", i), 32'(f_h), 32'(VEC[i].hb));
      chk($sformatf("R6 vbl flag vec%0d", i), 32'(f_v), 32'(VEC[i].vb));
    end

    // Full frame with all interrupts enabled, compare on line 2
    en_h = 1'b1; en_v = 1'b1; en_c = 1'b1; cmp_line = 8'd2;
    run_frame();
    chk("R4 irq_hbl per frame", c_ih, VIS + VBL);
    chk("R5 dma_hbl per frame", c_dh, VIS);
    chk("R6 irq_vbl per frame", c_iv, 1);
    chk("R6 dma_vbl per frame", c_dv, 1);
    chk("R6 frame_done per frame", c_fd, 1);
    chk("R8 render per frame", c_rs, VIS);
    chk("R7 irq_cmp per frame", c_ic, 1);
    chk("R5 R6 strobe region", c_bad, 0);

    // Interrupt enables off: DMA unaffected
    en_h = 1'b0; en_v = 1'b0; en_c = 1'b0;
    run_frame();
    chk("R4 R6 R7 irqs gated", c_ih + c_iv + c_ic, 0);
    chk("R5 dma_hbl still", c_dh, VIS);

    // R2 enable held low freezes everything
    adv_to(nedge + 3);
    cyc_en = 1'b0;
    c_bad = 0;
    for (int k = 0; k < 20; k++) begin
      step();
      c_bad += int'(i_h | i_v | i_c | d_h | d_v | fdone | rstb);
    end
    chk("R2 frozen phase", 32'(phase), 0);
    chk("R2 frozen line", 32'(line), 0);
    chk("R2 frozen pulses", c_bad, 0);
    cyc_en = 1'b1;
    adv_to(nedge + 3);
    chk("R2 hblank after resumed count", 32'(phase), 1);

    // R7 compare only re-evaluated on line change
    cmp_line = 8'd0;
    step();
    chk("R7 no recompute mid-line", 32'(f_c), 0);
    cmp_line = 8'd1;
    adv_to(nedge + 3);
    chk("R7 match on line 1", 32'(f_c), 1);
    adv_to(nedge + DRAW + HBL);
    chk("R7 cleared on line 2", 32'(f_c), 0);

    // Affine reference points, aligned to a frame start
    adv_to(((nedge / FRAME) + 1) * FRAME);
    org_x = {32'hFFFF_FFCE, 32'd100};
    org_y = {32'd0, 32'd1000};
    dx = {16'd7, 16'hFFFD};
    dy = {16'hFFFF, 16'd5};
    wx = 2'b11; wy = 2'b11;
    step();
    wx = 2'b00; wy = 2'b00;
    chk("R11 write x0", cur_x[31:0], 100);
    chk("R11 write y1", cur_y[63:32], 0);
    adv_to(nedge - 1 + DRAW + HBL);
    chk("R9 step x0", cur_x[31:0], 97);
    chk("R9 step y0", cur_y[31:0], 1005);
    chk("R9 step x1", cur_x[63:32], 32'hFFFF_FFD5);
    chk("R9 step y1", cur_y[63:32], 32'hFFFF_FFFF);
    org_x[31:0] = 32'd200;
    adv_to(nedge + 2 * (DRAW + HBL));
    chk("R9 origin change ignored", cur_x[31:0], 91);
    adv_to(nedge + DRAW + HBL);
    chk("R10 reload x0", cur_x[31:0], 200);
    chk("R10 reload y0", cur_y[31:0], 1000);
    chk("R10 reload x1", cur_x[63:32], 32'hFFFF_FFCE);

    // R11 write on the same edge as a line step
    adv_to(((nedge / FRAME) + 1) * FRAME + DRAW + HBL - 1);
    org_x[31:0] = 32'd500;
    wx = 2'b01;
    step();
    wx = 2'b00;
    chk("R11 write beats step x0", cur_x[31:0], 500);
    chk("R9 unwritten y0 steps", cur_y[31:0], 1005);
    adv_to(nedge + DRAW + HBL);
    chk("R9 step after write", cur_x[31:0], 497);

    finish_run();
  end

endmodule